// File: doc/BRIEF.md
# SPI Slave Register Access Controller

This block is an SPI slave, working in mode 0 with the most significant bit first, that serves a 64-entry by 8-bit register file. A master opens a transaction by pulling the active-low select low. The first byte it shifts in is a command. Its top bits choose one of three access kinds: register, frame buffer or SRAM. Each kind is a read or a write. A register command also carries a 6-bit address. The second byte then either returns the addressed register on MISO or brings the write data on MOSI.

SCK, MOSI and select are brought into the system clock domain through two-flop synchronizers, and all edges are detected there. While the command byte is shifted in, MISO returns zero by default. A 2-bit field in register 4 can switch this byte to a live status value taken from an input port. The block decodes frame buffer and SRAM commands and reports them with a one-cycle pulse on side outputs. Their data transfers are handled elsewhere.

Top module: `spi_regacc_slave`

## Requirements
- R1: After reset, all 64 registers read as zero, MISO is low, and neither pulse output is asserted.
- R2: Every byte moves most significant bit first, both in on MOSI and out on MISO.
- R3: A command with bit 7 = 1 and bit 6 = 1 writes the second MOSI byte to the register at command bits 5:0. Exactly one single-cycle write strobe follows, carrying that address and data.
- R4: A command with bit 7 = 1 and bit 6 = 0 returns the register at command bits 5:0 on MISO during the second byte.
- R5: The command-phase MISO byte is 0x00 while bits 1:0 of register 4 are 00. For any other value it is the status input. The field is sampled when select falls.
- R6: Command bits 7:5 = 001 (read) or 011 (write) give one single-cycle access pulse with mode code 01 and the direction flag equal to bit 6. No register is written.
- R7: Command bits 7:5 = 000 (read) or 010 (write) give one single-cycle access pulse with mode code 10 and the direction flag equal to bit 6. No register is written.
- R8: If select rises before a byte is complete, the transaction is dropped. No partial write takes place, and the next select fall starts a fresh command.
- R9: In a register access, MOSI bytes after the second one are ignored. They cause no further strobe, and the register holds the value from the second byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | SPI serial clock from the master, idle low |
| csn_i | input | 1 | Active-low slave select |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master |
| status_i | input | 8 | Status byte returned in the command phase when enabled |
| wr_stb_o | output | 1 | One-cycle pulse on a committed register write |
| wr_addr_o | output | 6 | Address of the committed write |
| wr_data_o | output | 8 | Data of the committed write |
| xfer_vld_o | output | 1 | One-cycle pulse on a decoded frame buffer or SRAM command |
| xfer_mode_o | output | 2 | 01 frame buffer, 10 SRAM |
| xfer_wr_o | output | 1 | Direction of the decoded access: 1 write, 0 read |

## Verification
Each SCK edge at the pin passes two synchronizer flops and one edge-detect comparison. A MISO bit therefore changes about three system clocks after a falling SCK. The write strobe or access pulse shows up about four clocks after the rising SCK that completes the byte. The bench holds each SCK phase for eight system clocks and samples MISO just before it raises SCK, so every bit has settled when it is read. Expected writes and access pulses go into queues as each transaction is driven. A monitor that samples on the falling system clock pops the queues when a pulse appears. Any pulse that arrives with no queued entry, and any entry still left at the end, counts as a failure.

// File: rtl/spi_regacc_pkg.sv
package spi_regacc_pkg;

  typedef enum logic [1:0] {
    XM_NONE  = 2'b00,
    XM_FRAME = 2'b01,
    XM_SRAM  = 2'b10
  } xmode_e;

  typedef struct packed {
    logic       is_reg;
    logic       is_wr;
    logic [5:0] addr;
    xmode_e     xm;
  } cmd_t;

  // Split a command byte into its access kind, direction and address.
  function automatic cmd_t decode_cmd(input logic [7:0] b);
    cmd_t c;
    c.is_reg = b[7];
    c.is_wr  = b[6];
    c.addr   = b[5:0];
    if (b[7])      c.xm = XM_NONE;
    else if (b[5]) c.xm = XM_FRAME;
    else           c.xm = XM_SRAM;
    return c;
  endfunction

  // Byte presented on MISO while the command shifts in.
  function automatic logic [7:0] cmd_phase_byte(input logic [1:0] sel,
                                                input logic [7:0] st);
    return (sel == 2'b00) ? 8'h00 : st;
  endfunction

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= {STAGES{RST_VAL[i]}};
      else        pipe <= {pipe[STAGES-2:0], d[i]};
    end
    assign q[i] = pipe[STAGES-1];
  end

endmodule

// File: rtl/spi_regfile.sv
module spi_regfile #(
  parameter int AW        = 6,
  parameter int DW        = 8,
  parameter int CTRL_ADDR = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  output logic [1:0]    ret_sel
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata   = mem[raddr];
  assign ret_sel = mem[CTRL_ADDR][1:0];

  // A commit must be visible at its address on the following cycle.
  assert_commit_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/spi_regacc_slave.sv
module spi_regacc_slave
  import spi_regacc_pkg::*;
#(
  parameter int AW        = 6,
  parameter int DW        = 8,
  parameter int SYNC_STG  = 2,
  parameter int CTRL_ADDR = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck_i,
  input  logic          csn_i,
  input  logic          mosi_i,
  output logic          miso_o,
  input  logic [DW-1:0] status_i,
  output logic          wr_stb_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          xfer_vld_o,
  output logic [1:0]    xfer_mode_o,
  output logic          xfer_wr_o
);

  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

  typedef enum logic [1:0] {PH_CMD, PH_DATA, PH_DONE} phase_e;

  // ---------------- input synchronization and edges ----------------
  logic sck_s, cs_s, mosi_s;
  logic sck_q, cs_q;

  spi_in_sync #(.W(3), .STAGES(SYNC_STG), .RST_VAL(3'b010)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({mosi_i, csn_i, sck_i}),
    .q     ({mosi_s, cs_s, sck_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck_s;
      cs_q  <= cs_s;
    end
  end

  logic sck_rise, sck_fall, cs_fall, cs_rise, active;
  assign active   = ~cs_s;
  assign sck_rise = active & sck_s & ~sck_q;
  assign sck_fall = active & ~sck_s & sck_q;
  assign cs_fall  = ~cs_s & cs_q;
  assign cs_rise  = cs_s & ~cs_q;

  // ---------------- shift state ----------------
  logic [CW-1:0] bit_cnt;
  logic [DW-1:0] rx_sh, tx_sh, tx_nxt;
  phase_e        phase;
  logic [AW-1:0] addr_q;
  logic          is_wr_q;

  logic [DW-1:0] rx_byte;
  logic          byte_done;
  cmd_t          cmd_now;
  assign rx_byte   = {rx_sh[DW-2:0], mosi_s};
  assign byte_done = sck_rise & (bit_cnt == LAST_BIT);
  assign cmd_now   = decode_cmd(rx_byte);

  // Named events for the checks below.
  logic commit_wr, xfer_hit;
  assign commit_wr = byte_done & (phase == PH_DATA) & is_wr_q;
  assign xfer_hit  = byte_done & (phase == PH_CMD) & ~cmd_now.is_reg;

  // ---------------- register file ----------------
  logic [DW-1:0] rf_rdata;
  logic [1:0]    ret_sel;

  spi_regfile #(.AW(AW), .DW(DW), .CTRL_ADDR(CTRL_ADDR)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (commit_wr),
    .waddr   (addr_q),
    .wdata   (rx_byte),
    .raddr   (cmd_now.addr),
    .rdata   (rf_rdata),
    .ret_sel (ret_sel)
  );

  // ---------------- control ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt     <= '0;
      rx_sh       <= '0;
      tx_sh       <= '0;
      tx_nxt      <= '0;
      phase       <= PH_CMD;
      addr_q      <= '0;
      is_wr_q     <= 1'b0;
      wr_stb_o    <= 1'b0;
      wr_addr_o   <= '0;
      wr_data_o   <= '0;
      xfer_vld_o  <= 1'b0;
      xfer_mode_o <= XM_NONE;
      xfer_wr_o   <= 1'b0;
    end else begin
      wr_stb_o   <= 1'b0;
      xfer_vld_o <= 1'b0;
      if (!active) begin
        bit_cnt <= '0;
        phase   <= PH_CMD;
        tx_sh   <= '0;
      end else begin
        if (cs_fall) tx_sh <= cmd_phase_byte(ret_sel, status_i);
        if (sck_rise) begin
          rx_sh   <= rx_byte;
          bit_cnt <= byte_done ? '0 : bit_cnt + 1'b1;
        end
        if (byte_done) begin
          tx_nxt <= '0;
          unique case (phase)
            PH_CMD: begin
              if (cmd_now.is_reg) begin
                phase   <= PH_DATA;
                addr_q  <= cmd_now.addr;
                is_wr_q <= cmd_now.is_wr;
                if (!cmd_now.is_wr) tx_nxt <= rf_rdata;
              end else begin
                phase       <= PH_DONE;
                xfer_vld_o  <= 1'b1;
                xfer_mode_o <= cmd_now.xm;
                xfer_wr_o   <= cmd_now.is_wr;
              end
            end
            PH_DATA: begin
              phase <= PH_DONE;
              if (is_wr_q) begin
                wr_stb_o  <= 1'b1;
                wr_addr_o <= addr_q;
                wr_data_o <= rx_byte;
              end
            end
            default: phase <= PH_DONE;
          endcase
        end
        if (sck_fall) tx_sh <= (bit_cnt == '0) ? tx_nxt : {tx_sh[DW-2:0], 1'b0};
      end
    end
  end

  assign miso_o = tx_sh[DW-1];

  // ---------------- assertions ----------------
  assert_wr_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |=> !wr_stb_o);

  assert_wr_follows_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_wr |=> wr_stb_o && wr_addr_o == $past(addr_q));

  assert_xfer_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_vld_o |=> !xfer_vld_o);

  assert_xfer_mode_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_vld_o |-> (xfer_mode_o == XM_FRAME || xfer_mode_o == XM_SRAM));

  assert_xfer_follows_decode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_hit |=> xfer_vld_o);

  assert_no_dual_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb_o && xfer_vld_o));

  assert_abort_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> bit_cnt == '0 && phase == PH_CMD);

endmodule

// File: tb/tb_spi_regacc_slave.sv
module tb_spi_regacc_slave;

  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, csn = 1'b1, mosi = 1'b0;
  logic [7:0] status = 8'h00;
  logic miso, wr_stb, xfer_vld, xfer_wr;
  logic [5:0] wr_addr;
  logic [7:0] wr_data;
  logic [1:0] xfer_mode;

  always #10 clk = ~clk;

  spi_regacc_slave dut (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .csn_i(csn), .mosi_i(mosi),
    .miso_o(miso), .status_i(status), .wr_stb_o(wr_stb), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .xfer_vld_o(xfer_vld), .xfer_mode_o(xfer_mode),
    .xfer_wr_o(xfer_wr)
  );

  int tests = 0, fails = 0;
  bit finished = 0;
  logic [7:0] model [64];
  logic [13:0] wq[$];
  logic [2:0]  xq[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_first();
    if (model[4][1:0] == 2'b00) return 8'h00;
    return status;
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 0; i < n; i++) begin
      mosi = tx[7-i];
      wait_clk(HALF);
      rx[7-i] = miso;
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic xact(input int n, input logic [7:0] b0, b1, b2, b3,
                      output logic [7:0] r0, output logic [7:0] r1);
    logic [7:0] bytes [4];
    logic [7:0] rx;
    bytes[0] = b0; bytes[1] = b1; bytes[2] = b2; bytes[3] = b3;
    r0 = 8'h00; r1 = 8'h00;
    csn = 1'b0;
    wait_clk(HALF);
    for (int k = 0; k < n; k++) begin
      spi_bits(bytes[k], 8, rx);
      if (k == 0) r0 = rx;
      if (k == 1) r1 = rx;
    end
    wait_clk(HALF);
    csn = 1'b1;
    wait_clk(2 * HALF);
  endtask

  task automatic reg_wr(input logic [5:0] a, input logic [7:0] d, input string req);
    logic [7:0] r0, r1, e0;
    e0 = exp_first();
    wq.push_back({a, d});
    xact(2, {2'b11, a}, d, 8'h00, 8'h00, r0, r1);
    chk(r0 == e0, {req, " R5 cmd-phase byte on write"}, r0, e0);
    model[a] = d;
  endtask

  task automatic reg_rd(input logic [5:0] a, input string req);
    logic [7:0] r0, r1, e0;
    e0 = exp_first();
    xact(2, {2'b10, a}, 8'hC3, 8'h00, 8'h00, r0, r1);
    chk(r0 == e0, {req, " R5 cmd-phase byte on read"}, r0, e0);
    chk(r1 == model[a], {req, " R4 read data"}, r1, model[a]);
  endtask

  task automatic side_cmd(input logic [7:0] c, input logic [1:0] m, input string req);
    logic [7:0] r0, r1;
    xq.push_back({m, c[6]});
    xact(2, c, 8'h5A, 8'h00, 8'h00, r0, r1);
  endtask

  // Monitor: pulses must match queued expectations in order.
  always @(negedge clk) begin
    if (rst_n && wr_stb) begin
      if (wq.size() == 0) chk(1'b0, "R3/R8/R9 unexpected write strobe", {wr_addr, wr_data}, 0);
      else begin
        logic [13:0] e;
        e = wq.pop_front();
        chk({wr_addr, wr_data} == e, "R3 write strobe addr/data", {wr_addr, wr_data}, e);
      end
    end
    if (rst_n && xfer_vld) begin
      if (xq.size() == 0) chk(1'b0, "R6/R7 unexpected access pulse", {xfer_mode, xfer_wr}, 0);
      else begin
        logic [2:0] e;
        e = xq.pop_front();
        chk({xfer_mode, xfer_wr} == e, "R6/R7 access mode/direction", {xfer_mode, xfer_wr}, e);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r0, r1;
    for (int i = 0; i < 64; i++) model[i] = 8'h00;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);

    // R1: reset state at the ports
    chk(miso == 1'b0, "R1 miso idle", miso, 0);
    chk(wr_stb == 1'b0 && xfer_vld == 1'b0, "R1 pulses low", {wr_stb, xfer_vld}, 0);
    reg_rd(6'h05, "R1");
    reg_rd(6'h3F, "R1");

    // R3/R4/R2: asymmetric patterns expose bit order
    reg_wr(6'h12, 8'h1D, "R3");
    reg_rd(6'h12, "R2");
    reg_wr(6'h3F, 8'hE1, "R3");
    reg_wr(6'h00, 8'h80, "R3");
    reg_wr(6'h21, 8'h01, "R3");
    reg_rd(6'h3F, "R4");
    reg_rd(6'h00, "R4");
    reg_rd(6'h21, "R2");

    // R5: status return mode field in register 4
    status = 8'h6B;
    reg_rd(6'h12, "R5 mode 00");
    reg_wr(6'h04, 8'h02, "R5");
    reg_rd(6'h12, "R5 mode 10");
    status = 8'h94;
    reg_wr(6'h04, 8'hFC, "R5");
    reg_rd(6'h04, "R5 mode 00 again");
    reg_wr(6'h04, 8'h03, "R5");
    reg_rd(6'h21, "R5 mode 11");
    reg_wr(6'h04, 8'h00, "R5");

    // R6: frame buffer commands
    side_cmd(8'h2A, 2'b01, "R6");
    side_cmd(8'h7F, 2'b01, "R6");
    // R7: SRAM commands
    side_cmd(8'h05, 2'b10, "R7");
    side_cmd(8'h55, 2'b10, "R7");
    reg_rd(6'h2A, "R6 no register touched");
    reg_rd(6'h15, "R7 no register touched");

    // R8: abort mid data byte, then mid command byte
    csn = 1'b0; wait_clk(HALF);
    spi_bits(8'hC7, 8, r0);
    spi_bits(8'hFF, 4, r1);
    csn = 1'b1; wait_clk(2 * HALF);
    reg_rd(6'h07, "R8 partial write dropped");
    csn = 1'b0; wait_clk(HALF);
    spi_bits(8'hC0, 3, r0);
    csn = 1'b1; wait_clk(2 * HALF);
    reg_wr(6'h07, 8'h4E, "R8 fresh command");
    reg_rd(6'h07, "R8 fresh command");

    // R9: bytes beyond the data byte are ignored
    wq.push_back({6'h09, 8'h33});
    xact(4, {2'b11, 6'h09}, 8'h33, 8'h44, 8'h55, r0, r1);
    model[9] = 8'h33;
    reg_rd(6'h09, "R9");

    wait_clk(20);
    chk(wq.size() == 0, "R3 missing write strobes", wq.size(), 0);
    chk(xq.size() == 0, "R6/R7 missing access pulses", xq.size(), 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule